// File: doc/BRIEF.md
# Decade Frequency Divider with Sync

This block turns a 10 MHz reference clock into three square waves at 100 Hz, 10 Hz and 1 Hz. All three run at the same time and are phase-coherent. A prescaler divides the reference down to a 2 kHz base tick. That tick drives a cascade of BCD decade digits, each counting 0 to 9 and carrying into the next. The slow outputs are the inverted bit 0 of the second, third and fourth digits. Because every output is taken from the same counter, an edge of a slower output always coincides with an edge of the faster ones.

An active-low arm input and a sync input give a one-time alignment to an external pulse-per-second edge. Holding arm low for the qualification time (about one second of reference clocks) stops the divider, clears every digit and drives all outputs high. The block then waits for the next rising edge on sync and restarts from zero, aligned to that edge. A shorter low pulse on arm is dropped and leaves the outputs untouched. A synchronous active-high reset brings the block up cleared and already running, with no sync edge needed.

Top module: `dfd_top`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, out_hi, out_mid and out_lo are all 1. Counting starts without any sync edge.
- R2: While running, the base tick occurs once every TICK_DIV clocks. out_hi is the inverse of bit 0 of digit TAP_HI, so it toggles every 10 ticks (every 10*TICK_DIV clocks).
- R3: out_mid is the inverse of bit 0 of digit TAP_MID and toggles every 100*TICK_DIV clocks while running.
- R4: out_lo is the inverse of bit 0 of digit TAP_LO and toggles every 1000*TICK_DIV clocks while running. A change on a slower output happens only on a clock where a faster output also changes, or where the chain is cleared.
- R5: When arm_n, after a two-flop synchronizer, is 0 for ARM_HOLD consecutive clocks, the divider stops and all digits clear. All three outputs are then 1 and stay 1 while the block waits.
- R6: A low pulse on arm_n shorter than ARM_HOLD synchronized clocks has no effect. The outputs keep counting exactly as if the pulse had never occurred.
- R7: While waiting, only a 0-to-1 transition of the synchronized sync_in restarts the divider. A sync_in held at 1 from before the wait, and the release of arm_n, do not restart it. Sync edges while running are ignored.
- R8: If sync_in rises just after clock edge n, the divider runs from edge n+3. out_hi falls at edge n+3+10*TICK_DIV and out_mid falls at edge n+3+100*TICK_DIV.
- R9: In steady state no reference cycle is gained or lost. The output sequence matches an exact count of base ticks, modulo 10^N_DIGITS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (10 MHz in the target use) |
| rst | input | 1 | Synchronous active-high reset |
| arm_n | input | 1 | Active-low arm request; asynchronous to clk |
| sync_in | input | 1 | Alignment pulse (1PPS); its rising edge restarts an armed divider |
| out_hi | output | 1 | Fastest decade output (100 Hz at defaults) |
| out_mid | output | 1 | Middle decade output (10 Hz at defaults) |
| out_lo | output | 1 | Slowest decade output (1 Hz at defaults) |

## Verification
The assertions take for granted that reset is held for at least two clocks at start-up. They also assume that arm_n and sync_in reach the logic only through the synchronizer, so a sync rise and an arm level are each seen as whole clock cycles. The bench drives both inputs only on the falling clock edge and holds reset for four cycles. It builds the divider with a small tick divisor and a short arm hold, so the long qualification and the 1 Hz period both fit in a short run. The arm pulses are sized well clear of the hold threshold on either side, so the cancel case and the qualify case are never borderline.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
   typedef logic [3:0] bcd_t;
   localparam bcd_t BCD_TOP = 4'd9;
   typedef enum logic {ST_RUN = 1'b0, ST_WAIT = 1'b1} mode_t;
endpackage

// File: rtl/dfd_sync2.sv
module dfd_sync2 #(
   parameter int             W       = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage1 <= RST_VAL;
         q      <= RST_VAL;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end
endmodule

// File: rtl/dfd_prescaler.sv
module dfd_prescaler #(
   parameter int DIV = 5000
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 1) begin : g_passthru
         assign tick = en;
      end else begin : g_count
         logic [CW-1:0] cnt;
         logic          at_end;
         assign at_end = (cnt == CW'(DIV - 1));
         assign tick   = en && at_end;
         always_ff @(posedge clk) begin
            if (rst || clr)  cnt <= '0;
            else if (en)     cnt <= at_end ? '0 : cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/dfd_decade_chain.sv
module dfd_decade_chain
   import dfd_pkg::*;
#(
   parameter int N       = 5,
   parameter int TAP_HI  = 1,
   parameter int TAP_MID = 2,
   parameter int TAP_LO  = 3
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       clr,
   input  logic       inc,
   output logic [2:0] tap_lsb
);
   bcd_t           dig   [N];
   logic [N-1:0]   carry;

   assign carry[0] = inc;

   generate
      for (genvar i = 0; i < N; i++) begin : g_digit
         always_ff @(posedge clk) begin
            if (rst || clr)        dig[i] <= '0;
            else if (carry[i])     dig[i] <= (dig[i] == BCD_TOP) ? '0 : dig[i] + 1'b1;
         end
         if (i < N - 1) begin : g_carry
            assign carry[i+1] = carry[i] && (dig[i] == BCD_TOP);
         end
      end
   endgenerate

   assign tap_lsb = {dig[TAP_HI][0], dig[TAP_MID][0], dig[TAP_LO][0]};
endmodule

// File: rtl/dfd_ctrl.sv
module dfd_ctrl
   import dfd_pkg::*;
#(
   parameter int ARM_HOLD = 10_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic arm_s,
   input  logic sync_s,
   output logic waiting,
   output logic sync_rise,
   output logic clr,
   output logic run_en
);
   localparam int HW = $clog2(ARM_HOLD);

   mode_t          st;
   logic           sync_d;
   logic [HW-1:0]  hold;
   logic           arm_done;

   assign sync_rise = sync_s && !sync_d;
   assign arm_done  = (st == ST_RUN) && !arm_s && (hold == HW'(ARM_HOLD - 1));
   assign waiting   = (st == ST_WAIT);
   assign run_en    = (st == ST_RUN);
   assign clr       = arm_done || waiting;

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_RUN;
         hold   <= '0;
         sync_d <= 1'b0;
      end else begin
         sync_d <= sync_s;
         unique case (st)
            ST_RUN: begin
               if (arm_done) begin
                  st   <= ST_WAIT;
                  hold <= '0;
               end else if (!arm_s) begin
                  hold <= hold + 1'b1;
               end else begin
                  hold <= '0;
               end
            end
            ST_WAIT: begin
               hold <= '0;
               if (sync_rise) st <= ST_RUN;
            end
            default: st <= ST_RUN;
         endcase
      end
   end
endmodule

// File: rtl/dfd_top.sv
module dfd_top #(
   parameter int TICK_DIV = 5000,
   parameter int ARM_HOLD = 10_000_000,
   parameter int N_DIGITS = 5,
   parameter int TAP_HI   = 1,
   parameter int TAP_MID  = 2,
   parameter int TAP_LO   = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic arm_n,
   input  logic sync_in,
   output logic out_hi,
   output logic out_mid,
   output logic out_lo
);
   generate
      if (TICK_DIV < 1)
         $error("dfd_top: TICK_DIV must be at least 1");
      if (ARM_HOLD < 2)
         $error("dfd_top: ARM_HOLD must be at least 2");
      if (!(TAP_HI < TAP_MID && TAP_MID < TAP_LO && TAP_LO < N_DIGITS && TAP_HI >= 0))
         $error("dfd_top: taps must rise strictly and fit inside the chain");
   endgenerate

   logic [1:0] in_s;
   logic       arm_s, sync_s;
   logic       waiting, sync_rise, clr, run_en, tick;
   logic [2:0] lsb;

   dfd_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({arm_n, sync_in}),
      .q   (in_s)
   );
   assign arm_s  = in_s[1];
   assign sync_s = in_s[0];

   dfd_ctrl #(.ARM_HOLD(ARM_HOLD)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .arm_s     (arm_s),
      .sync_s    (sync_s),
      .waiting   (waiting),
      .sync_rise (sync_rise),
      .clr       (clr),
      .run_en    (run_en)
   );

   dfd_prescaler #(.DIV(TICK_DIV)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .en   (run_en),
      .tick (tick)
   );

   dfd_decade_chain #(
      .N       (N_DIGITS),
      .TAP_HI  (TAP_HI),
      .TAP_MID (TAP_MID),
      .TAP_LO  (TAP_LO)
   ) u_chain (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .inc     (tick),
      .tap_lsb (lsb)
   );

   assign out_hi  = ~lsb[2];
   assign out_mid = ~lsb[1];
   assign out_lo  = ~lsb[0];
endmodule

// File: rtl/dfd_top_chk.sv
module dfd_top_chk (
   input logic clk,
   input logic rst,
   input logic out_hi,
   input logic out_mid,
   input logic out_lo,
   input logic waiting,
   input logic sync_rise,
   input logic arm_s,
   input logic tick,
   input logic clr
);
   // R5: a waiting divider shows all outputs high
   a_r5_wait_outputs_high: assert property (@(posedge clk) disable iff (rst)
      waiting |-> (out_hi && out_mid && out_lo));

   // R5: the wait state is only entered after a low synchronized arm
   a_r5_enter_needs_arm: assert property (@(posedge clk) disable iff (rst)
      $rose(waiting) |-> $past(!arm_s));

   // R7: without a sync rise the divider keeps waiting
   a_r7_stay_waiting: assert property (@(posedge clk) disable iff (rst)
      (waiting && !sync_rise) |=> waiting);

   // R8: a sync rise while waiting restarts on the next clock
   a_r8_restart_after_rise: assert property (@(posedge clk) disable iff (rst)
      (waiting && sync_rise) |=> !waiting);

   // R2: outputs move only after a base tick or a clear
   a_r2_change_on_tick: assert property (@(posedge clk) disable iff (rst)
      !$stable({out_hi, out_mid, out_lo}) |-> $past(tick || clr));

   // R4: slower outputs change only together with the faster one, or on clear
   a_r4_mid_follows_hi: assert property (@(posedge clk) disable iff (rst)
      !$stable(out_mid) |-> (!$stable(out_hi) || $past(clr)));

   a_r4_lo_follows_mid: assert property (@(posedge clk) disable iff (rst)
      !$stable(out_lo) |-> (!$stable(out_mid) || $past(clr)));
endmodule

bind dfd_top dfd_top_chk chk_i (
   .clk       (clk),
   .rst       (rst),
   .out_hi    (out_hi),
   .out_mid   (out_mid),
   .out_lo    (out_lo),
   .waiting   (waiting),
   .sync_rise (sync_rise),
   .arm_s     (arm_s),
   .tick      (tick),
   .clr       (clr)
);

// File: tb/dfd_top_tb_top.sv
`timescale 1ns/1ps
module dfd_top_tb_top;
   localparam int DIV  = 5;
   localparam int HOLD = 40;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic arm_n = 1'b1;
   logic sync_in = 1'b0;
   logic out_hi, out_mid, out_lo;

   int    checks = 0;
   int    fails  = 0;
   int    cyc    = 0;
   bit    cmp_on = 0;
   bit    done   = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   dfd_top #(.TICK_DIV(DIV), .ARM_HOLD(HOLD)) dut_i (
      .clk     (clk),
      .rst     (rst),
      .arm_n   (arm_n),
      .sync_in (sync_in),
      .out_hi  (out_hi),
      .out_mid (out_mid),
      .out_lo  (out_lo)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // Behavioural reference: ticks counted as an integer, inputs delayed by queues
   int   m_pre, m_ticks, m_hold;
   bit   m_run, m_rise;
   bit   arm_q[$];
   bit   sync_q[$];
   bit   m_sd;

   always @(posedge clk) begin
      if (rst) begin
         m_pre = 0; m_ticks = 0; m_hold = 0; m_run = 1; m_sd = 0;
         arm_q = '{1'b1, 1'b1};
         sync_q = '{1'b0, 1'b0};
      end else begin
         m_rise = sync_q[0] && !m_sd;
         if (m_run) begin
            if (!arm_q[0] && m_hold == HOLD - 1) begin
               m_run = 0; m_pre = 0; m_ticks = 0; m_hold = 0;
            end else begin
               m_hold = arm_q[0] ? 0 : m_hold + 1;
               if (m_pre == DIV - 1) begin
                  m_pre = 0;
                  m_ticks = (m_ticks + 1) % 100000;
               end else begin
                  m_pre = m_pre + 1;
               end
            end
         end else begin
            m_pre = 0; m_ticks = 0; m_hold = 0;
            if (m_rise) m_run = 1;
         end
         m_sd = sync_q[0];
         void'(arm_q.pop_front());
         arm_q.push_back(arm_n);
         void'(sync_q.pop_front());
         sync_q.push_back(sync_in);
      end
   end

   always @(negedge clk) begin
      if (!rst && cmp_on)
         check(cur_req, {29'd0, out_hi, out_mid, out_lo},
               {29'd0, ((m_ticks / 10) % 2) == 0, ((m_ticks / 100) % 2) == 0,
                ((m_ticks / 1000) % 2) == 0}, "outputs vs reference");
   end

   // Edge monitor
   logic p_hi = 1'b1, p_mid = 1'b1, p_lo = 1'b1;
   int hi_cnt = 0, hi_last = 0, hi_prev = 0;
   int mid_last = 0, mid_prev = 0, lo_last = 0, lo_prev = 0;
   int hi_fall = 0, mid_fall = 0;

   always @(negedge clk) begin
      if (!rst) begin
         if (out_hi !== p_hi) begin
            hi_cnt++; hi_prev = hi_last; hi_last = cyc;
            if (!out_hi) hi_fall = cyc;
         end
         if (out_mid !== p_mid) begin
            mid_prev = mid_last; mid_last = cyc;
            if (!out_mid) mid_fall = cyc;
         end
         if (out_lo !== p_lo) begin
            lo_prev = lo_last; lo_last = cyc;
         end
      end
      p_hi = out_hi; p_mid = out_mid; p_lo = out_lo;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int e0, n;
      repeat (4) @(negedge clk);
      check("R1", {29'd0, out_hi, out_mid, out_lo}, 7, "outputs during reset");
      rst = 1'b0;
      cmp_on = 1;
      @(negedge clk);
      check("R1", {29'd0, out_hi, out_mid, out_lo}, 7, "outputs after reset");

      cur_req = "R9";
      repeat (10500) @(negedge clk);
      check("R2", hi_last - hi_prev, 10 * DIV, "out_hi half period");
      check("R3", mid_last - mid_prev, 100 * DIV, "out_mid half period");
      check("R4", lo_last - lo_prev, 1000 * DIV, "out_lo half period");

      cur_req = "R6";
      e0 = hi_cnt;
      arm_n = 1'b0;
      repeat (HOLD - 5) @(negedge clk);
      arm_n = 1'b1;
      repeat (20 * DIV) @(negedge clk);
      check("R6", int'(hi_cnt - e0 >= 2), 1, "out_hi kept toggling after short arm");

      cur_req = "R7";
      sync_in = 1'b1;
      repeat (10) @(negedge clk);
      sync_in = 1'b0;
      repeat (30) @(negedge clk);
      sync_in = 1'b1;
      repeat (10) @(negedge clk);

      cur_req = "R5";
      arm_n = 1'b0;
      repeat (HOLD + 10) @(negedge clk);
      check("R5", {29'd0, out_hi, out_mid, out_lo}, 7, "outputs high after arm hold");

      cur_req = "R7";
      e0 = hi_cnt;
      repeat (200) @(negedge clk);
      check("R7", hi_cnt - e0, 0, "no toggles while waiting with sync level high");
      arm_n = 1'b1;
      repeat (100) @(negedge clk);
      check("R7", {29'd0, out_hi, out_mid, out_lo}, 7, "outputs high after arm release");
      check("R7", hi_cnt - e0, 0, "no restart on arm release");
      sync_in = 1'b0;
      repeat (10) @(negedge clk);

      cur_req = "R8";
      sync_in = 1'b1;
      n = cyc;
      while (hi_fall <= n) @(negedge clk);
      check("R8", hi_fall, n + 3 + 10 * DIV, "first out_hi fall clock");
      while (mid_fall <= n) @(negedge clk);
      check("R8", mid_fall, n + 3 + 100 * DIV, "first out_mid fall clock");

      cur_req = "R9";
      repeat (6000) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule